// File: doc/BRIEF.md
# Single-Channel Memory-to-Peripheral DMA Engine

This block moves a block of bytes from memory to one peripheral while the CPU does other work. Software writes a starting memory address, a byte count and a control word through a small write-only register port. The control word selects one of three bus-release policies and starts the channel. The peripheral then raises its request line. The engine asks the CPU for the bus, waits for the grant, and moves each byte as a fly-by transfer. In that transfer it drives the memory address, pulses the memory-read strobe and then the I/O-write strobe, and the byte passes directly from memory to the device on the shared data bus.

The three policies set how long the engine keeps the bus. Single mode gives the bus back after every byte. Block mode keeps it until the count is used up. Demand mode keeps it for as long as the peripheral keeps requesting, and continues from the same address and count when the request returns. When the last byte has been written, the engine gives the bus back and sets a completion interrupt. The interrupt stays set until software clears it.

Top module: `dma_mover`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, hrq, dack, mem_rd, io_wr and irq are all low.
- R2: A write with cfg_sel=0 loads the start address and a write with cfg_sel=1 loads the byte count. A write with cfg_sel=2 carries the mode in bits [1:0] (0 single, 1 block, 2 demand, 3 behaves as single) and a start flag in bit 2. Address writes, count writes and starts are ignored while busy is high.
- R3: hrq rises only while busy, the peripheral is requesting and hlda is low. No strobe is driven until hlda has been seen high, and hrq stays high for every cycle the engine owns the bus.
- R4: Each byte is one clock of mem_rd followed directly by one clock of io_wr, with dack high in both clocks and addr unchanged between them. The two strobes are never high together.
- R5: The address of byte i is start+i modulo 2^ADDR_W, and exactly count bytes are moved.
- R6: In single mode hrq is low in the cycle after every io_wr, so the bus is requested again for each byte.
- R7: In block mode, once granted, hrq stays high until the last byte, even if the peripheral drops its request.
- R8: In demand mode, if the request is low when a byte ends, hrq drops and no further strobes occur. When the request returns, the transfer continues at the next address with the remaining count.
- R9: In the cycle after the last io_wr, busy and hrq are low and irq is high.
- R10: irq stays high until a write with cfg_sel=3 clears it. Other register writes leave it set.
- R11: A start with a byte count of zero is refused: busy and hrq stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control/start, 3 clear interrupt |
| cfg_wdata | input | WDATA_W | Register write data |
| busy | output | 1 | Channel started and not yet finished |
| irq | output | 1 | Sticky completion interrupt |
| dreq | input | 1 | Service request from the peripheral |
| dack | output | 1 | Acknowledge to the peripheral during a byte transfer |
| hrq | output | 1 | Bus hold request to the CPU |
| hlda | input | 1 | Bus hold grant from the CPU |
| addr | output | ADDR_W | Memory address of the current byte |
| mem_rd | output | 1 | Memory read strobe |
| io_wr | output | 1 | Peripheral write strobe |

## Verification
The hardest case to reach is the demand-mode pause. The request must fall in exactly the cycle a byte ends, so that the engine gives up the bus in the middle of a block, and it must later resume at the right address. A directed test watches the byte count from the ports and drops the request right after the third write strobe. It checks that the bus is released with the channel still busy, then raises the request again and checks that the address sequence has no gap. Random demand runs toggle the request every cycle to reach many more pause and resume points. A second hard case is a start written in the middle of a transfer. The bench issues it while a block transfer is running and checks that the running address sequence and byte count are not disturbed.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_BLOCK  = 2'd1,
    MODE_DEMAND = 2'd2,
    MODE_ALT    = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_HOLD,
    ST_RD,
    ST_WR
  } seq_state_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_CLEAR = 2'd3;
  localparam int         START_BIT = 2;

  // Next state once a byte's write strobe completes.
  function automatic seq_state_e after_byte(input xfer_mode_e m,
                                            input logic last,
                                            input logic req);
    if (last) return ST_IDLE;
    case (m)
      MODE_BLOCK:  return ST_RD;
      MODE_DEMAND: return req ? ST_RD : ST_ARMED;
      default:     return ST_ARMED;
    endcase
  endfunction

endpackage

// File: rtl/dma_mover_regs.sv
module dma_mover_regs
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 16,
  parameter int WDATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [WDATA_W-1:0] cfg_wdata,
  input  logic               busy,
  input  logic               step,
  output logic               start_go,
  output logic               last_byte,
  output xfer_mode_e         mode,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic               irq
);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  xfer_mode_e        mode_q;
  logic              irq_q;

  function automatic logic [ADDR_W-1:0] bump_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] drop_count(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  logic wr_addr, wr_cnt, wr_ctrl, wr_clear;
  assign wr_addr  = cfg_we && (cfg_sel == SEL_ADDR)  && !busy;
  assign wr_cnt   = cfg_we && (cfg_sel == SEL_COUNT) && !busy;
  assign wr_ctrl  = cfg_we && (cfg_sel == SEL_CTRL);
  assign wr_clear = cfg_we && (cfg_sel == SEL_CLEAR);

  assign start_go  = wr_ctrl && cfg_wdata[START_BIT] && !busy && (cnt_q != '0);
  assign last_byte = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      mode_q <= MODE_SINGLE;
      irq_q  <= 1'b0;
    end else begin
      if (wr_addr)      addr_q <= cfg_wdata[ADDR_W-1:0];
      else if (step)    addr_q <= bump_addr(addr_q);
      if (wr_cnt)       cnt_q  <= cfg_wdata[CNT_W-1:0];
      else if (step)    cnt_q  <= drop_count(cnt_q);
      if (start_go)     mode_q <= xfer_mode_e'(cfg_wdata[1:0]);
      if (step && last_byte) irq_q <= 1'b1;
      else if (wr_clear)     irq_q <= 1'b0;
    end
  end

  assign mode     = mode_q;
  assign cur_addr = addr_q;
  assign irq      = irq_q;

endmodule

// File: rtl/dma_mover_seq.sv
module dma_mover_seq
  import dma_mover_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_go,
  input  xfer_mode_e mode,
  input  logic       last_byte,
  input  logic       dreq,
  input  logic       hlda,
  output logic       busy,
  output logic       hrq,
  output logic       dack,
  output logic       mem_rd,
  output logic       io_wr,
  output logic       step
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_go) state_d = ST_ARMED;
      ST_ARMED: if (dreq && !hlda) state_d = ST_HOLD;
      ST_HOLD:  if (hlda) state_d = ST_RD;
      ST_RD:    state_d = ST_WR;
      ST_WR:    state_d = after_byte(mode, last_byte, dreq);
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy   = (state_q != ST_IDLE);
  assign hrq    = (state_q == ST_HOLD) || (state_q == ST_RD) || (state_q == ST_WR);
  assign dack   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_rd = (state_q == ST_RD);
  assign io_wr  = (state_q == ST_WR);
  assign step   = (state_q == ST_WR);

endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 16,
  parameter int WDATA_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [WDATA_W-1:0] cfg_wdata,
  output logic               busy,
  output logic               irq,
  input  logic               dreq,
  output logic               dack,
  output logic               hrq,
  input  logic               hlda,
  output logic [ADDR_W-1:0]  addr,
  output logic               mem_rd,
  output logic               io_wr
);

  logic       start_go;
  logic       last_byte;
  logic       step;
  xfer_mode_e mode;

  dma_mover_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .WDATA_W(WDATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .busy     (busy),
    .step     (step),
    .start_go (start_go),
    .last_byte(last_byte),
    .mode     (mode),
    .cur_addr (addr),
    .irq      (irq)
  );

  dma_mover_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_go (start_go),
    .mode     (mode),
    .last_byte(last_byte),
    .dreq     (dreq),
    .hlda     (hlda),
    .busy     (busy),
    .hrq      (hrq),
    .dack     (dack),
    .mem_rd   (mem_rd),
    .io_wr    (io_wr),
    .step     (step)
  );

endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic              busy,
  input logic              irq,
  input logic              dack,
  input logic              hrq,
  input logic              hlda,
  input logic [ADDR_W-1:0] addr,
  input logic              mem_rd,
  input logic              io_wr
);

  a_r3_strobe_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || io_wr) |-> (hrq && hlda));

  a_r3_hold_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    hrq |-> busy);

  a_r3_ack_while_owned: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> hrq);

  a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (io_wr && $stable(addr)));

  a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> $past(mem_rd));

  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && io_wr));

  a_r9_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (!hrq && !busy));

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(cfg_we && cfg_sel == 2'd3)) |=> irq);

endmodule

bind dma_mover dma_mover_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cfg_we (cfg_we),
  .cfg_sel(cfg_sel),
  .busy   (busy),
  .irq    (irq),
  .dack   (dack),
  .hrq    (hrq),
  .hlda   (hlda),
  .addr   (addr),
  .mem_rd (mem_rd),
  .io_wr  (io_wr)
);

// File: tb/sim_dma_mover.sv
`timescale 1ns/1ps
module sim_dma_mover;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        dreq = 1'b0;
  logic        hlda = 1'b0;
  logic        busy, irq, dack, hrq, mem_rd, io_wr;
  logic [15:0] addr;

  always #2 clk = ~clk;

  dma_mover u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .irq(irq), .dreq(dreq),
    .dack(dack), .hrq(hrq), .hlda(hlda), .addr(addr),
    .mem_rd(mem_rd), .io_wr(io_wr)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // Bench view of the transfer in flight
  logic [15:0] exp_addr = 16'd0;
  logic [15:0] rd_addr = 16'd0;
  int  exp_count = 0;
  int  bytes_seen = 0;
  int  cur_mode = 0;
  int  hrq_falls = 0;
  bit  active = 1'b0;
  bit  prev_hrq = 1'b0;
  bit  prev_rd = 1'b0;
  bit  done_pending = 1'b0;
  bit  rel_pending = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit single_like(input int m);
    return (m == 0) || (m == 3);
  endfunction

  // Monitor plus CPU hold responder, all away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_pending) begin
        chk(!busy && !hrq && irq, "R9", "busy/hrq/irq after last byte",
            {busy, hrq, irq}, 3'b001);
        done_pending = 1'b0;
      end
      if (rel_pending) begin
        chk(!hrq, "R6", "hrq after single byte", hrq, 0);
        rel_pending = 1'b0;
      end
      if (active && prev_hrq && !hrq) hrq_falls++;
      prev_hrq = hrq;
      if (mem_rd) begin
        chk(addr == exp_addr, "R5", "read address", addr, exp_addr);
        chk(dack && hlda, "R3", "dack/hlda during read", {dack, hlda}, 3);
        rd_addr = addr;
      end
      if (io_wr) begin
        chk(prev_rd && addr == rd_addr && dack, "R4", "write follows read at same address",
            addr, rd_addr);
        exp_addr = exp_addr + 16'd1;
        bytes_seen++;
        if (bytes_seen == exp_count) done_pending = 1'b1;
        else if (single_like(cur_mode)) rel_pending = 1'b1;
      end
      prev_rd = mem_rd;
      if (!hrq) hlda = 1'b0;
      else if (!hlda && ($urandom % 3 == 0)) hlda = 1'b1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_xfer(input logic [15:0] a, input int n, input int m);
    exp_addr = a; exp_count = n; bytes_seen = 0; cur_mode = m;
    hrq_falls = 0; active = 1'b1;
    cfg_write(2'd0, a);
    cfg_write(2'd1, 16'(n));
    cfg_write(2'd2, 16'(m) | 16'h4);
    chk(busy, "R2", "busy after start", busy, 1);
  endtask

  // dmode 0: hold request high, 1: drop after grant, 2: random toggling
  task automatic run_to_done(input int dmode);
    int guard = 0;
    dreq = 1'b1;
    while (busy && guard < 5000) begin
      @(negedge clk); #1;
      if (dmode == 1 && hrq) dreq = 1'b0;
      if (dmode == 2) dreq = ($urandom % 4 != 0);
      guard++;
    end
    dreq = 1'b0;
    @(negedge clk); #1;
    active = 1'b0;
  endtask

  task automatic finish_checks(input logic [15:0] a, input int n);
    chk(bytes_seen == n, "R5", "bytes moved", bytes_seen, n);
    chk(exp_addr == a + 16'(n), "R5", "end address", exp_addr, a + 16'(n));
    if (single_like(cur_mode)) chk(hrq_falls == n, "R6", "bus releases", hrq_falls, n);
    if (cur_mode == 1) chk(hrq_falls == 1, "R7", "bus releases", hrq_falls, 1);
    if (cur_mode == 2) chk(hrq_falls >= 1 && hrq_falls <= n, "R8", "bus releases", hrq_falls, 1);
    chk(irq, "R10", "irq held after done", irq, 1);
    cfg_write(2'd3, 16'd0);
    chk(!irq, "R10", "irq after clear", irq, 0);
  endtask

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    chk(!busy && !hrq && !dack && !mem_rd && !io_wr && !irq, "R1", "outputs in reset",
        {busy, hrq, dack, mem_rd, io_wr, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !hrq && !irq, "R1", "outputs after reset", {busy, hrq, irq}, 0);

    // R11: zero count refused
    cfg_write(2'd1, 16'd0);
    cfg_write(2'd2, 16'h4);
    dreq = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !hrq, "R11", "zero-count start", {busy, hrq}, 0);
    dreq = 1'b0;

    // R6 single mode, directed
    start_xfer(16'h0040, 5, 0);
    run_to_done(0);
    finish_checks(16'h0040, 5);

    // R7 block mode with request dropped after grant, also mid-run start refused (R2)
    start_xfer(16'h0100, 6, 1);
    dreq = 1'b1;
    while (bytes_seen < 1) begin @(negedge clk); #1; if (hrq) dreq = 1'b0; end
    cfg_write(2'd0, 16'h0500);
    cfg_write(2'd1, 16'd3);
    cfg_write(2'd2, 16'h6);
    run_to_done(1);
    finish_checks(16'h0100, 6);

    // R8 demand pause after three bytes, then resume
    start_xfer(16'h0200, 7, 2);
    dreq = 1'b1;
    while (bytes_seen < 3) begin @(negedge clk); #1; end
    dreq = 1'b0;
    repeat (10) @(negedge clk);
    chk(bytes_seen == 3, "R8", "bytes during pause", bytes_seen, 3);
    chk(busy && !hrq, "R8", "busy/hrq during pause", {busy, hrq}, 2);
    run_to_done(0);
    finish_checks(16'h0200, 7);

    // R5 address wrap, block mode
    start_xfer(16'hFFFE, 4, 1);
    run_to_done(0);
    finish_checks(16'hFFFE, 4);

    // R2 mode 3 behaves as single
    start_xfer(16'h0300, 3, 3);
    run_to_done(0);
    finish_checks(16'h0300, 3);

    // R10 other writes leave irq set
    start_xfer(16'h0010, 2, 1);
    run_to_done(0);
    repeat (5) @(negedge clk);
    cfg_write(2'd0, 16'h1234);
    chk(irq, "R10", "irq after unrelated write", irq, 1);
    finish_checks(16'h0010, 2);

    // Random mix
    for (int i = 0; i < 24; i++) begin
      logic [15:0] a;
      int n, m;
      a = 16'($urandom);
      n = 1 + int'($urandom % 20);
      m = int'($urandom % 4);
      start_xfer(a, n, m);
      run_to_done(m == 2 ? 2 : (m == 1 ? 1 : 0));
      finish_checks(a, n);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule